// File: doc/BRIEF.md
# Matrix Keypad Scan Engine

This block scans a key matrix of up to sixteen rows and eight columns. It works from a slow scan clock. It pulls the enabled rows low one at a time and reads the column lines, which have pull-ups, so a low column marks a closed key. Each row is held for a fixed settle time plus a programmable debounce stretch. A column counts as pressed only if it reads low for the whole debounce stretch. After the last enabled row, the keys found are published as a snapshot of up to eight byte-wide entries, together with a count and a one-cycle update pulse.

While no key is down, the engine idles with every enabled row pulled low and waits for any column to fall. When a column falls, it raises an activity flag and waits a programmable initial delay. It then polls continuously. Each scan starts with a short lead-in, walks the rows, and then waits a programmable repeat gap. A scan that finds nothing publishes an empty snapshot, drops the activity flag and goes back to idle.

All counts are in scan-clock cycles. The entry layout requires at most sixteen rows and eight columns.

Top module: `keypad_scan_engine`

## Requirements
- R1: Out of reset, all row drives are high, `snap_count` is 0, `key_active` is low and `snap_upd` is low.
- R2: When enabled and idle, exactly the enabled rows are driven low. A column going low raises `key_active` on the third rising edge after the change, because the column path has two synchronizer stages.
- R3: While `cfg_enable` is low, all rows are driven high, and `key_active` is low from the next cycle on.
- R4: During a scan, exactly one row is driven low at a time, and the rows are visited in ascending index order. A row whose `cfg_row_en` bit is 0 is never driven, and keys on that row are never reported.
- R5: In continuous polling, consecutive `snap_upd` pulses are max(repeat,1) + 5 + N·(16 + debounce) cycles apart, where N is the number of enabled rows. A repeat count of zero still takes one cycle.
- R6: A key is recorded only if its column reads low on every cycle from the 16th cycle of its row window to the window's end, which is debounce + 1 samples. A column that chatters within that stretch is not recorded.
- R7: Each entry is one byte: bit 7 = valid, bits 6:3 = row, bits 2:0 = column. Entry slot k occupies `snap_entries[8k+7:8k]`. Slots at or above `snap_count` read as zero.
- R8: Entries are filled in ascending row order, then ascending column order. At most eight are kept, and any further keys are dropped. `snap_count` never exceeds 8.
- R9: `snap_upd` is a single-cycle pulse. `snap_entries` and `snap_count` change only together with it.
- R10: A scan that finds no key publishes `snap_count` = 0, clears `key_active` in the same cycle, and returns to idle.
- R11: After detection, the enabled rows stay driven low for max(initial delay,1) cycles. The rows are then all released for the 5-cycle lead-in of the first scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_debounce | input | 10 | Debounce cycles added to each row window |
| cfg_repeat | input | 16 | Gap between scans in polling mode |
| cfg_init_dly | input | 20 | Delay from first detection to first scan |
| cfg_row_en | input | 16 | Per-row scan enable |
| col_in_n | input | 8 | Column lines, low = key closed on the driven row |
| row_drv_n | output | 16 | Row drives, low = row selected |
| snap_entries | output | 64 | Eight packed snapshot entries |
| snap_count | output | 4 | Number of valid entries |
| snap_upd | output | 1 | One-cycle pulse when a snapshot is published |
| key_active | output | 1 | High from detection until an empty scan |

## Verification
A wrong row pointer or a wrong phase counter shows up on the row drives within one row window. It also shifts the distance between snapshot pulses, which the bench measures against the period formula on every polling pair. A corrupted debounce accumulator or entry buffer shows up in the next published snapshot, at most one scan period later, as a wrong entry byte or count. The bench compares these against an independent model of the pressed-key set. A stale activity flag or idle state shows up after an empty scan: either the flag stays high, or the rows fail to return to the enabled pattern in the same cycle as the empty snapshot pulse.

// File: rtl/kps_pkg.sv
package kps_pkg;
  localparam int ENT_W     = 8;
  localparam int VALID_BIT = 7;
  localparam int ROW_LSB   = 3;
  localparam int ROW_FW    = 4;
  localparam int COL_FW    = 3;
  localparam int LEAD_CYC  = 5;
  localparam int ROW_BASE  = 16;

  typedef logic [ENT_W-1:0] ent_t;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_HOLD,
    SEQ_LEAD,
    SEQ_ROW,
    SEQ_GAP
  } seq_st_e;
endpackage

// File: rtl/kps_sync.sv
module kps_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] s1_q, s2_q;

  // Resets to all ones: the pulled-up, no-key level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_in;
      s2_q <= s1_q;
    end
  end

  assign d_out = s2_q;
endmodule

// File: rtl/kps_sequencer.sv
module kps_sequencer
  import kps_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int DB_W   = 10,
  parameter int RPT_W  = 16,
  parameter int INIT_W = 20,
  parameter int RIDX_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DB_W-1:0]   db,
  input  logic [RPT_W-1:0]  rpt,
  input  logic [INIT_W-1:0] init_dly,
  input  logic [ROWS-1:0]   row_en,
  input  logic              any_low,
  input  logic              found,
  output logic [ROWS-1:0]   row_drv_n,
  output logic [RIDX_W-1:0] row_idx,
  output logic              win_first,
  output logic              win_sample,
  output logic              row_last,
  output logic              scan_start,
  output logic              scan_done,
  output logic              key_active
);
  localparam int TW0   = (INIT_W > RPT_W) ? INIT_W : RPT_W;
  localparam int TMR_W = ((TW0 > DB_W + 5) ? TW0 : DB_W + 5) + 1;

  seq_st_e           st_q, st_d;
  logic [TMR_W-1:0]  cnt_q, cnt_d, cnt_inc, row_len;
  logic [RIDX_W-1:0] row_q, row_d, first_idx, next_idx;
  logic              act_q, act_d;
  logic              has_first, has_next;
  logic              hold_end, lead_end, row_end, gap_end;

  // Lowest enabled row overall, and lowest enabled row above the current one.
  always_comb begin
    has_first = 1'b0;
    first_idx = '0;
    has_next  = 1'b0;
    next_idx  = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (row_en[r]) begin
        has_first = 1'b1;
        first_idx = RIDX_W'(r);
      end
      if (row_en[r] && (r > int'(row_q))) begin
        has_next = 1'b1;
        next_idx = RIDX_W'(r);
      end
    end
  end

  // Phase-end conditions; a zero-length phase still takes one cycle.
  always_comb begin
    cnt_inc  = cnt_q + 1'b1;
    row_len  = TMR_W'(ROW_BASE) + TMR_W'(db);
    hold_end = cnt_inc >= TMR_W'(init_dly);
    lead_end = cnt_inc >= TMR_W'(LEAD_CYC);
    row_end  = cnt_inc >= row_len;
    gap_end  = cnt_inc >= TMR_W'(rpt);
  end

  always_comb begin
    win_sample = en && (st_q == SEQ_ROW) && (cnt_q >= TMR_W'(ROW_BASE - 1));
    win_first  = en && (st_q == SEQ_ROW) && (cnt_q == TMR_W'(ROW_BASE - 1));
    row_last   = en && (st_q == SEQ_ROW) && row_end;
    scan_start = en && (st_q == SEQ_LEAD) && (cnt_q == '0);
    scan_done  = (row_last && !has_next) ||
                 (en && (st_q == SEQ_LEAD) && lead_end && !has_first);
  end

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_inc;
    row_d = row_q;
    act_d = act_q;
    if (!en) begin
      st_d  = SEQ_IDLE;
      cnt_d = '0;
      act_d = 1'b0;
    end else begin
      case (st_q)
        SEQ_IDLE: begin
          cnt_d = '0;
          if (any_low) begin
            st_d  = SEQ_HOLD;
            act_d = 1'b1;
          end
        end
        SEQ_HOLD: begin
          if (hold_end) begin
            st_d  = SEQ_LEAD;
            cnt_d = '0;
          end
        end
        SEQ_LEAD: begin
          if (lead_end) begin
            cnt_d = '0;
            if (has_first) begin
              st_d  = SEQ_ROW;
              row_d = first_idx;
            end else begin
              st_d  = SEQ_IDLE;
              act_d = 1'b0;
            end
          end
        end
        SEQ_ROW: begin
          if (row_end) begin
            cnt_d = '0;
            if (has_next) begin
              row_d = next_idx;
            end else if (found) begin
              st_d = SEQ_GAP;
            end else begin
              st_d  = SEQ_IDLE;
              act_d = 1'b0;
            end
          end
        end
        SEQ_GAP: begin
          if (gap_end) begin
            st_d  = SEQ_LEAD;
            cnt_d = '0;
          end
        end
        default: begin
          st_d  = SEQ_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      row_q <= '0;
      act_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      row_q <= row_d;
      act_q <= act_d;
    end
  end

  // Row drive decode
  always_comb begin
    row_drv_n = '1;
    if (en) begin
      case (st_q)
        SEQ_IDLE, SEQ_HOLD: row_drv_n = ~row_en;
        SEQ_ROW:            row_drv_n[row_q] = 1'b0;
        default:            row_drv_n = '1;
      endcase
    end
  end

  assign row_idx    = row_q;
  assign key_active = act_q;

  // R3
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !act_q);
  // R4
  row_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~row_drv_n) & ~row_en) == '0);
  // R4
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_q == SEQ_ROW) |-> $onehot(~row_drv_n));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_IDLE) |-> !act_q);
endmodule

// File: rtl/kps_collector.sv
module kps_collector
  import kps_pkg::*;
#(
  parameter int COLS    = 8,
  parameter int MAX_ENT = 8,
  parameter int RIDX_W  = 4,
  parameter int CNT_W   = $clog2(MAX_ENT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [RIDX_W-1:0]        row_idx,
  input  logic [COLS-1:0]          col_n,
  input  logic                     win_first,
  input  logic                     win_sample,
  input  logic                     row_last,
  input  logic                     scan_start,
  input  logic                     scan_done,
  output logic                     found,
  output logic [MAX_ENT*ENT_W-1:0] snap_entries,
  output logic [CNT_W-1:0]         snap_count,
  output logic                     snap_upd
);
  localparam int IDX_W = (MAX_ENT > 1) ? $clog2(MAX_ENT) : 1;

  logic [COLS-1:0]  acc_q, acc_d;
  ent_t             work_q [MAX_ENT];
  ent_t             app    [MAX_ENT];
  ent_t             pub_q  [MAX_ENT];
  logic [CNT_W-1:0] wcnt_q, app_cnt, pcnt_q;
  logic             upd_q;
  ent_t             ent;

  // Debounce accumulator and in-order append of this row's keys.
  always_comb begin
    acc_d = acc_q;
    if (win_sample) acc_d = (win_first ? {COLS{1'b1}} : acc_q) & ~col_n;
    app     = work_q;
    app_cnt = wcnt_q;
    ent     = '0;
    if (row_last) begin
      for (int c = 0; c < COLS; c++) begin
        if (acc_d[c] && (app_cnt < CNT_W'(MAX_ENT))) begin
          ent = '0;
          ent[VALID_BIT]            = 1'b1;
          ent[ROW_LSB +: ROW_FW]    = ROW_FW'(row_idx);
          ent[0 +: COL_FW]          = COL_FW'(c);
          app[app_cnt[IDX_W-1:0]]   = ent;
          app_cnt                   = app_cnt + 1'b1;
        end
      end
    end
  end

  assign found = (app_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      wcnt_q <= '0;
      pcnt_q <= '0;
      upd_q  <= 1'b0;
      for (int i = 0; i < MAX_ENT; i++) begin
        work_q[i] <= '0;
        pub_q[i]  <= '0;
      end
    end else begin
      acc_q <= acc_d;
      upd_q <= scan_done;
      if (scan_start) begin
        wcnt_q <= '0;
        for (int i = 0; i < MAX_ENT; i++) work_q[i] <= '0;
      end else if (row_last) begin
        wcnt_q <= app_cnt;
        for (int i = 0; i < MAX_ENT; i++) work_q[i] <= app[i];
      end
      if (scan_done) begin
        pcnt_q <= app_cnt;
        for (int i = 0; i < MAX_ENT; i++) pub_q[i] <= app[i];
      end
    end
  end

  for (genvar g = 0; g < MAX_ENT; g++) begin : g_flat
    assign snap_entries[g*ENT_W +: ENT_W] = pub_q[g];

    // R7
    slot_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pcnt_q <= CNT_W'(g)) |-> !pub_q[g][VALID_BIT]);
  end

  assign snap_count = pcnt_q;
  assign snap_upd   = upd_q;

  // R9
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= CNT_W'(MAX_ENT));
  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |=> $stable(pcnt_q));
endmodule

// File: rtl/keypad_scan_engine.sv
module keypad_scan_engine
  import kps_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int COLS    = 8,
  parameter int MAX_ENT = 8,
  parameter int DB_W    = 10,
  parameter int RPT_W   = 16,
  parameter int INIT_W  = 20,
  localparam int RIDX_W = $clog2(ROWS),
  localparam int CNT_W  = $clog2(MAX_ENT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_enable,
  input  logic [DB_W-1:0]          cfg_debounce,
  input  logic [RPT_W-1:0]         cfg_repeat,
  input  logic [INIT_W-1:0]        cfg_init_dly,
  input  logic [ROWS-1:0]          cfg_row_en,
  input  logic [COLS-1:0]          col_in_n,
  output logic [ROWS-1:0]          row_drv_n,
  output logic [MAX_ENT*ENT_W-1:0] snap_entries,
  output logic [CNT_W-1:0]         snap_count,
  output logic                     snap_upd,
  output logic                     key_active
);
  logic [COLS-1:0]   col_s;
  logic [RIDX_W-1:0] row_idx;
  logic              any_low, found;
  logic              win_first, win_sample, row_last, scan_start, scan_done;

  kps_sync #(.W(COLS)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (col_in_n),
    .d_out (col_s)
  );

  assign any_low = |(~col_s);

  kps_sequencer #(
    .ROWS   (ROWS),
    .DB_W   (DB_W),
    .RPT_W  (RPT_W),
    .INIT_W (INIT_W),
    .RIDX_W (RIDX_W)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cfg_enable),
    .db         (cfg_debounce),
    .rpt        (cfg_repeat),
    .init_dly   (cfg_init_dly),
    .row_en     (cfg_row_en),
    .any_low    (any_low),
    .found      (found),
    .row_drv_n  (row_drv_n),
    .row_idx    (row_idx),
    .win_first  (win_first),
    .win_sample (win_sample),
    .row_last   (row_last),
    .scan_start (scan_start),
    .scan_done  (scan_done),
    .key_active (key_active)
  );

  kps_collector #(
    .COLS    (COLS),
    .MAX_ENT (MAX_ENT),
    .RIDX_W  (RIDX_W),
    .CNT_W   (CNT_W)
  ) i_col (
    .clk          (clk),
    .rst_n        (rst_n),
    .row_idx      (row_idx),
    .col_n        (col_s),
    .win_first    (win_first),
    .win_sample   (win_sample),
    .row_last     (row_last),
    .scan_start   (scan_start),
    .scan_done    (scan_done),
    .found        (found),
    .snap_entries (snap_entries),
    .snap_count   (snap_count),
    .snap_upd     (snap_upd)
  );
endmodule

// File: tb/test_keypad_scan_engine.sv
`timescale 1ns/1ps
module test_keypad_scan_engine;
  localparam int ROWS = 16;
  localparam int COLS = 8;
  localparam int MAXE = 8;
  localparam int NK   = ROWS * COLS;
  localparam int CH_R = 5;
  localparam int CH_C = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            en;
  logic [9:0]      db;
  logic [15:0]     rpt;
  logic [19:0]     initd;
  logic [ROWS-1:0] row_en;
  logic [COLS-1:0] col_n;
  logic [ROWS-1:0] row_drv_n;
  logic [63:0]     snap_entries;
  logic [3:0]      snap_count;
  logic            snap_upd;
  logic            key_active;

  logic [NK-1:0]   press;
  logic            chat_on = 1'b0;
  logic            chat_ph = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int guard_bad = 0, scan_bad = 0, pulse_bad = 0;
  logic prev_upd = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) chat_ph <= ~chat_ph;

  keypad_scan_engine i_keypad_scan_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (en),
    .cfg_debounce (db),
    .cfg_repeat   (rpt),
    .cfg_init_dly (initd),
    .cfg_row_en   (row_en),
    .col_in_n     (col_n),
    .row_drv_n    (row_drv_n),
    .snap_entries (snap_entries),
    .snap_count   (snap_count),
    .snap_upd     (snap_upd),
    .key_active   (key_active)
  );

  // Key matrix model: closed key connects its column to its driven row.
  always_comb begin
    col_n = '1;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (press[r*COLS + c] && !row_drv_n[r]) col_n[c] = 1'b0;
    if (chat_on && chat_ph && !row_drv_n[CH_R]) col_n[CH_C] = 1'b0;
  end

  // Continuous row-drive and pulse-width monitor (R4, R9)
  always @(negedge clk) begin
    if (rst_n && en) begin
      if (((~row_drv_n) & ~row_en) != '0) guard_bad++;
      if (((~row_drv_n) != row_en) && ($countones(~row_drv_n) > 1)) scan_bad++;
    end
    if (rst_n && snap_upd && prev_upd) pulse_bad++;
    prev_upd <= snap_upd;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int exp_cnt(input logic [NK-1:0] p, input logic [ROWS-1:0] ren);
    int n = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (ren[r] && p[r*COLS + c] && n < MAXE) n++;
    return n;
  endfunction

  function automatic logic [63:0] exp_ent(input logic [NK-1:0] p, input logic [ROWS-1:0] ren);
    logic [63:0] ev = '0;
    int n = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (ren[r] && p[r*COLS + c] && n < MAXE) begin
          ev[n*8 +: 8] = {1'b1, 4'(r), 3'(c)};
          n++;
        end
    return ev;
  endfunction

  task automatic wait_snap(output bit ok);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!snap_upd && t < 6000);
    ok = snap_upd;
  endtask

  task automatic run_trial(input logic [NK-1:0] p, input string req);
    bit ok;
    int n1, c1, per;
    press = p;
    wait_snap(ok);
    n1 = snap_count;
    c1 = cyc;
    wait_snap(ok);
    chk(ok, req, "snapshot pulse seen", 64'(ok), 64'd1);
    chk(snap_count == 4'(exp_cnt(p, row_en)), "R8", "entry count",
        64'(snap_count), 64'(exp_cnt(p, row_en)));
    chk(snap_entries == exp_ent(p, row_en), req, "entry bytes",
        snap_entries, exp_ent(p, row_en));
    if (n1 != 0) begin
      per = ((rpt == 0) ? 1 : int'(rpt)) + 5 + $countones(row_en) * (16 + int'(db));
      chk((cyc - c1) == per, "R5", "scan period", 64'(cyc - c1), 64'(per));
    end
  endtask

  task automatic set_cfg(input logic [9:0] d, input logic [15:0] r,
                         input logic [19:0] i, input logic [ROWS-1:0] re);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(row_drv_n == '1, "R3", "rows released while off", 64'(row_drv_n), 64'hFFFF);
    chk(!key_active, "R3", "activity low while off", 64'(key_active), 64'd0);
    db = d; rpt = r; initd = i; row_en = re;
    @(negedge clk);
    en = 1'b1;
  endtask

  function automatic logic [NK-1:0] make_pat(input int mode, input logic [ROWS-1:0] ren);
    logic [NK-1:0] p = '0;
    int fr = 0;
    for (int k = 0; k < NK / 32; k++) begin
      case (mode)
        0: p[k*32 +: 32] = $urandom & $urandom & $urandom;
        1: p[k*32 +: 32] = $urandom | $urandom;
        default: p[k*32 +: 32] = '0;
      endcase
    end
    for (int r = ROWS - 1; r >= 0; r--) if (ren[r]) fr = r;
    p[fr*COLS + $urandom_range(0, COLS - 1)] = 1'b1;
    return p;
  endfunction

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int lat;
    bit ok;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; en = 1'b0; db = 10'd3; rpt = 16'd7; initd = 20'd6;
    row_en = '1; press = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(row_drv_n == '1, "R1", "rows after reset", 64'(row_drv_n), 64'hFFFF);
    chk(snap_count == 0, "R1", "count after reset", 64'(snap_count), 64'd0);
    chk(!key_active && !snap_upd, "R1", "flags after reset",
        64'({key_active, snap_upd}), 64'd0);

    en = 1'b1;
    repeat (2) @(negedge clk);
    chk(row_drv_n == ~row_en, "R2", "idle row pattern", 64'(row_drv_n), 64'(~row_en));

    // R2 detection latency, R11 hold phase
    press = '0;
    press[2*COLS + 5] = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!key_active && lat < 10);
    chk(lat == 3, "R2", "detection latency", 64'(lat), 64'd3);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 5) chk(row_drv_n == ~row_en, "R11", "rows held low", 64'(row_drv_n), 64'(~row_en));
      if (k == 6) chk(row_drv_n == '1, "R11", "lead-in releases rows", 64'(row_drv_n), 64'hFFFF);
    end
    run_trial(press, "R7");

    // R8 truncation: all keys down
    run_trial('1, "R8");

    // Random trials across several configurations (R4 disabled rows, R7 layout)
    for (int t = 0; t < 24; t++) begin
      if (t % 8 == 0) begin
        logic [ROWS-1:0] re;
        re = ROWS'($urandom);
        re[$urandom_range(0, ROWS - 1)] = 1'b1;
        set_cfg(10'($urandom_range(0, 6)), 16'($urandom_range(0, 20)),
                20'($urandom_range(0, 10)), re);
      end
      run_trial(make_pat(t % 3, row_en), "R4");
    end

    // R6 chatter rejection
    set_cfg(10'd4, 16'd3, 20'd2, '1);
    chat_on = 1'b1;
    press = '0;
    press[1*COLS + 1] = 1'b1;
    run_trial(press, "R6");

    // R10 release returns to idle
    chat_on = 1'b0;
    press = '0;
    for (int k = 0; k < 3; k++) begin
      wait_snap(ok);
      if (snap_count == 0) break;
    end
    chk(snap_count == 0, "R10", "empty snapshot", 64'(snap_count), 64'd0);
    chk(!key_active, "R10", "activity cleared with empty pulse", 64'(key_active), 64'd0);
    chk(row_drv_n == ~row_en, "R10", "idle rows after release", 64'(row_drv_n), 64'(~row_en));

    // R3 disable
    en = 1'b0;
    @(negedge clk);
    chk(row_drv_n == '1 && !key_active, "R3", "off state",
        64'({row_drv_n, key_active}), 64'h1FFFE);

    chk(guard_bad == 0, "R4", "disabled row driven", 64'(guard_bad), 64'd0);
    chk(scan_bad == 0, "R4", "multiple rows in scan", 64'(scan_bad), 64'd0);
    chk(pulse_bad == 0, "R9", "snapshot pulse width", 64'(pulse_bad), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule